// File: doc/BRIEF.md
# Serial Command Word Sender for a Dual-Channel DAC

This block feeds a write-only serial digital-to-analog converter with 32-bit command words. A 32-bit word is presented on a parallel input. While the block is idle, it compares the input with the last word it sent. When the input holds a new value, the block shifts that word out as a single 32-bit frame. The frame goes out on a clock line, a data line and an active-low frame-select line. The converter's load line is held low at all times, so each new setting takes effect as soon as its frame completes. Nothing is read back, so the system has to keep its own record of what the converter holds.

Within a frame, bits 27:24 carry the operation code, bits 23:20 pick the target channel and bits 19:4 carry the 16-bit output code. The top nibble and the bottom nibble carry no meaning, and the block always sends zeros there. For example, the word 0x03F00000 plus a code shifted left by four writes and updates every channel at once. A word that changes while a frame is on the wire is held and sent once that frame and the inter-frame gap are over. A busy output shows when a frame is in flight. The serial clock rate is a fixed fraction of the system clock, set by a parameter.

Top module: `dac_frame_tx`

## Requirements
- R1: In idle, an input word whose cleaned value (bits 31:28 and 3:0 forced to zero) differs from the last word sent starts a frame: one clock later dac_sync_n is 0 and busy is 1.
- R2: A frame carries exactly 32 bits, most significant first. The converter takes each bit on a falling edge of dac_sclk. dac_sync_n stays low for exactly 32 serial clock periods, and dac_sclk is high when dac_sync_n falls.
- R3: dac_load_n is 0 in every cycle.
- R4: Bits 31:28 and 3:0 of every frame are 0. Bits 27:4 (operation 27:24, channel 23:20, code 19:4) match the input word.
- R5: While dac_sync_n stays low, dac_din changes only in the cycle in which dac_sclk rises.
- R6: While dac_sync_n is high, dac_sclk is 1 and dac_din is 0.
- R7: Between two frames, dac_sync_n stays high for at least two serial clock periods.
- R8: busy is 1 exactly while dac_sync_n is 0.
- R9: An input change that touches only bits 31:28 or 3:0 starts no frame, and neither does an input whose cleaned value equals the last word sent.
- R10: A new word that appears during a frame or the gap after it is captured and sent next. This holds even if the input goes back to the last sent word before the frame ends.
- R11: One dac_sclk period lasts DIV_RATIO system clocks. DIV_RATIO is even and at least 2.
- R12: Reset puts dac_sync_n at 1, dac_sclk at 1, dac_din at 0 and busy at 0, and sets the last-sent reference to 0, so an all-zero input after reset sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_in | input | 32 | Command word to be sent |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sync_n | output | 1 | Active-low frame select |
| dac_din | output | 1 | Serial data, MSB first |
| dac_load_n | output | 1 | Converter load line, constant 0 |
| busy | output | 1 | Frame in flight |

## Verification
The hardest case to reach from the ports is the hand-off of a word that only flickers on the input while a frame is being shifted. Such a word never shows in idle, so it is sent only if the capture path holds it. The bench waits for the frame-select line to fall and then holds a fresh word for three cycles. It then puts the old word back on the input and expects three frames in order: the old word, the fresh word, and the old word again. A bit-level receiver in the bench rebuilds every frame from the falling serial clock edges. It also measures the frame length, the clock period and the gap between frames.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

    localparam int FRAME_W    = 32;
    localparam int HI_PAD     = 4;
    localparam int LO_PAD     = 4;
    localparam int GAP_HALVES = 4;
    localparam int BITCNT_W   = $clog2(FRAME_W + 1);
    localparam int GAPCNT_W   = $clog2(GAP_HALVES);

    localparam logic [FRAME_W-1:0] FRAME_KEEP =
        {{HI_PAD{1'b0}}, {(FRAME_W - HI_PAD - LO_PAD){1'b1}}, {LO_PAD{1'b0}}};

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SHIFT,
        TX_GAP
    } tx_state_e;

    typedef struct packed {
        tx_state_e             st;
        logic                  sclk;
        logic                  sync_n;
        logic [BITCNT_W-1:0]   falls;
        logic [GAPCNT_W-1:0]   gaps;
    } tx_ctl_t;

    function automatic logic [FRAME_W-1:0] clean_frame(input logic [FRAME_W-1:0] w);
        return w & FRAME_KEEP;
    endfunction

endpackage

// File: rtl/dac_sclk_tick.sv
module dac_sclk_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run)
            cnt_d = '0;
        else if (cnt_q == LAST)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/dac_shift_out.sv
module dac_shift_out #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sreg_d, sreg_q;

    always_comb begin
        sreg_d = sreg_q;
        if (load)
            sreg_d = load_word;
        else if (shift)
            sreg_d = {sreg_q[W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sreg_q <= '0;
        else        sreg_q <= sreg_d;
    end

    assign msb = sreg_q[W-1];
endmodule

// File: rtl/dac_word_watch.sv
module dac_word_watch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] word_in,
    input  logic         idle,
    input  logic         take,
    output logic         start_req,
    output logic [W-1:0] start_word
);
    logic [W-1:0] last_d, last_q;
    logic [W-1:0] pend_d, pend_q;
    logic         pend_v_d, pend_v_q;

    assign start_word = pend_v_q ? pend_q : word_in;
    assign start_req  = idle && (pend_v_q || (word_in != last_q));

    always_comb begin
        last_d   = last_q;
        pend_d   = pend_q;
        pend_v_d = pend_v_q;
        if (take) begin
            last_d   = start_word;
            pend_v_d = 1'b0;
        end else if (!idle && (word_in != last_q)) begin
            pend_d   = word_in;
            pend_v_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q   <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
        end else begin
            last_q   <= last_d;
            pend_q   <= pend_d;
            pend_v_q <= pend_v_d;
        end
    end
endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
    import dac_tx_pkg::*;
#(
    parameter int DIV_RATIO = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] word_in,
    output logic        dac_sclk,
    output logic        dac_sync_n,
    output logic        dac_din,
    output logic        dac_load_n,
    output logic        busy
);
    localparam int HALF_DIV = DIV_RATIO / 2;
    localparam logic [BITCNT_W-1:0] LAST_FALL = BITCNT_W'(FRAME_W);
    localparam logic [GAPCNT_W-1:0] LAST_GAP  = GAPCNT_W'(GAP_HALVES - 1);

    tx_ctl_t ctl_d, ctl_q;

    logic               tick;
    logic               load, shift, take;
    logic               start_req;
    logic [FRAME_W-1:0] start_word;
    logic [FRAME_W-1:0] clean_in;

    assign clean_in = clean_frame(word_in);

    dac_sclk_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctl_q.st != TX_IDLE),
        .tick  (tick)
    );

    dac_word_watch #(.W(FRAME_W)) u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_in    (clean_in),
        .idle       (ctl_q.st == TX_IDLE),
        .take       (take),
        .start_req  (start_req),
        .start_word (start_word)
    );

    dac_shift_out #(.W(FRAME_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (start_word),
        .shift     (shift),
        .msb       (dac_din)
    );

    always_comb begin
        ctl_d = ctl_q;
        load  = 1'b0;
        shift = 1'b0;
        take  = 1'b0;
        unique case (ctl_q.st)
            TX_IDLE: begin
                if (start_req) begin
                    take         = 1'b1;
                    load         = 1'b1;
                    ctl_d.sync_n = 1'b0;
                    ctl_d.falls  = '0;
                    ctl_d.st     = TX_SHIFT;
                end
            end
            TX_SHIFT: begin
                if (tick) begin
                    if (ctl_q.sclk) begin
                        ctl_d.sclk  = 1'b0;
                        ctl_d.falls = ctl_q.falls + 1'b1;
                    end else begin
                        ctl_d.sclk = 1'b1;
                        shift      = 1'b1;
                        if (ctl_q.falls == LAST_FALL) begin
                            ctl_d.sync_n = 1'b1;
                            ctl_d.gaps   = '0;
                            ctl_d.st     = TX_GAP;
                        end
                    end
                end
            end
            TX_GAP: begin
                if (tick) begin
                    if (ctl_q.gaps == LAST_GAP)
                        ctl_d.st = TX_IDLE;
                    else
                        ctl_d.gaps = ctl_q.gaps + 1'b1;
                end
            end
            default: ctl_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st     <= TX_IDLE;
            ctl_q.sclk   <= 1'b1;
            ctl_q.sync_n <= 1'b1;
            ctl_q.falls  <= '0;
            ctl_q.gaps   <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dac_sclk   = ctl_q.sclk;
    assign dac_sync_n = ctl_q.sync_n;
    assign dac_load_n = 1'b0;
    assign busy       = !ctl_q.sync_n;
endmodule

// File: rtl/dac_frame_tx_chk.sv
module dac_frame_tx_chk #(
    parameter int DIV_RATIO = 4
) (
    input logic clk,
    input logic rst_n,
    input logic dac_sclk,
    input logic dac_sync_n,
    input logic dac_din
);
    localparam int FRAME_CYC = 32 * DIV_RATIO;
    localparam int GAP_MIN   = 2 * DIV_RATIO;

    logic [31:0] low_cnt, high_cnt;
    logic        seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            high_cnt <= '0;
            seen_q   <= 1'b0;
        end else begin
            if (dac_sync_n) begin
                low_cnt  <= '0;
                high_cnt <= high_cnt + 1'b1;
            end else begin
                low_cnt  <= low_cnt + 1'b1;
                high_cnt <= '0;
                seen_q   <= 1'b1;
            end
        end
    end

    AST_DIN_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_sync_n && $past(!dac_sync_n) && !$stable(dac_din)) |-> $rose(dac_sclk)); // R5

    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sync_n |-> dac_sclk); // R6

    AST_DIN_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sync_n |-> !dac_din); // R6

    AST_SYNC_FALL_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sync_n) |-> dac_sclk); // R2

    AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sync_n) |-> (low_cnt == 32'(FRAME_CYC))); // R2

    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dac_sync_n) && seen_q) |-> (high_cnt >= 32'(GAP_MIN))); // R7
endmodule

bind dac_frame_tx dac_frame_tx_chk #(.DIV_RATIO(DIV_RATIO)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dac_sclk   (dac_sclk),
    .dac_sync_n (dac_sync_n),
    .dac_din    (dac_din)
);

// File: tb/sim_dac_frame_tx.sv
module sim_dac_frame_tx;
    localparam int DIV = 4;
    localparam int NVEC = 8;

    // {input word, expected frame}
    localparam logic [63:0] VEC [0:NVEC-1] = '{
        {32'h03F0_1230, 32'h03F0_1230},
        {32'hF3F0_ABCF, 32'h03F0_ABC0},
        {32'h0310_FFF0, 32'h0310_FFF0},
        {32'hA020_0005, 32'h0020_0000},
        {32'h0FFF_FFFF, 32'h0FFF_FFF0},
        {32'h0000_0010, 32'h0000_0010},
        {32'h8000_0001, 32'h0000_0000},
        {32'h03F0_8000, 32'h03F0_8000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] word_in = '0;
    logic        dac_sclk, dac_sync_n, dac_din, dac_load_n, busy;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    dac_frame_tx #(.DIV_RATIO(DIV)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_in    (word_in),
        .dac_sclk   (dac_sclk),
        .dac_sync_n (dac_sync_n),
        .dac_din    (dac_din),
        .dac_load_n (dac_load_n),
        .busy       (busy)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // receiver model
    logic [31:0] frames [0:63];
    int          frame_cnt = 0;
    logic        p_sclk = 1'b1, p_sync = 1'b1, p_din = 1'b0;
    logic [31:0] rx_sh;
    int bits, low_len, gap_len, last_fall, cyc;
    int per_bad, din_bad, idle_bad, busy_bad, load_bad;
    logic have_frame = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            p_sclk = 1'b1; p_sync = 1'b1; p_din = 1'b0;
            have_frame = 1'b0; gap_len = 0;
        end else begin
            if (dac_load_n !== 1'b0) load_bad++;
            if (busy !== !dac_sync_n) busy_bad++;
            if (p_sync && !dac_sync_n) begin
                if (have_frame)
                    chk(gap_len >= 2 * DIV, "R7 gap", gap_len, 2 * DIV);
                chk(p_sclk == 1'b1, "R2 sclk high at select", 32'(p_sclk), 1);
                bits = 0; rx_sh = '0; low_len = 0; last_fall = -1;
                per_bad = 0; din_bad = 0;
            end
            if (!dac_sync_n) begin
                low_len++;
                if (!p_sync && (dac_din != p_din) && !(!p_sclk && dac_sclk)) din_bad++;
                if (p_sclk && !dac_sclk) begin
                    rx_sh = {rx_sh[30:0], dac_din};
                    bits++;
                    if (last_fall >= 0 && (cyc - last_fall) != DIV) per_bad++;
                    last_fall = cyc;
                end
            end else begin
                gap_len++;
                if (!dac_sclk || dac_din) idle_bad++;
            end
            if (!p_sync && dac_sync_n) begin
                chk(bits == 32, "R2 bit count", bits, 32);
                chk(low_len == 32 * DIV, "R2 select length", low_len, 32 * DIV);
                chk(per_bad == 0, "R11 sclk period", per_bad, 0);
                chk(din_bad == 0, "R5 din timing", din_bad, 0);
                if (frame_cnt < 64) frames[frame_cnt] = rx_sh;
                frame_cnt++;
                gap_len = 0;
                have_frame = 1'b1;
            end
            p_sclk = dac_sclk; p_sync = dac_sync_n; p_din = dac_din;
        end
    end

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            bad++; total++;
            $display("FAIL R1 watchdog actual=%0d expected<150000", wd);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_frames(input int n);
        for (int i = 0; i < 2000 && frame_cnt < n; i++) @(negedge clk);
    endtask

    task automatic settle();
        for (int i = 0; i < 4 * DIV + 4; i++) @(negedge clk);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(dac_sync_n == 1'b1 && dac_sclk == 1'b1 && dac_din == 1'b0 && busy == 1'b0,
            "R12 reset outputs", {dac_sync_n, dac_sclk, dac_din, busy}, 32'hC);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        chk(frame_cnt == 0, "R12 zero input sends nothing", frame_cnt, 0);

        for (int v = 0; v < NVEC; v++) begin
            base = frame_cnt;
            word_in = VEC[v][63:32];
            @(negedge clk);
            chk(dac_sync_n == 1'b0 && busy == 1'b1, "R1 start latency",
                {dac_sync_n, busy}, 32'h1);
            wait_frames(base + 1);
            chk(frame_cnt == base + 1, "R1 one frame", frame_cnt, base + 1);
            chk(frames[base] == VEC[v][31:0], "R4 frame content", frames[base], VEC[v][31:0]);
            settle();
        end

        // R9: only the don't-care nibbles change
        base = frame_cnt;
        word_in = 32'hF3F0_800F;
        repeat (300) @(negedge clk);
        chk(frame_cnt == base && dac_sync_n == 1'b1, "R9 pad-only change ignored", frame_cnt, base);
        word_in = 32'h03F0_8000;
        repeat (100) @(negedge clk);
        chk(frame_cnt == base, "R9 same word ignored", frame_cnt, base);

        // R10: short-lived word during a frame
        base = frame_cnt;
        word_in = 32'h0155_AAA0;
        @(negedge clk);
        repeat (10) @(negedge clk);
        word_in = 32'h0266_5550;
        repeat (3) @(negedge clk);
        word_in = 32'h0155_AAA0;
        wait_frames(base + 3);
        chk(frame_cnt == base + 3, "R10 frame count", frame_cnt, base + 3);
        chk(frames[base] == 32'h0155_AAA0, "R10 first", frames[base], 32'h0155_AAA0);
        chk(frames[base + 1] == 32'h0266_5550, "R10 captured", frames[base + 1], 32'h0266_5550);
        chk(frames[base + 2] == 32'h0155_AAA0, "R10 restored", frames[base + 2], 32'h0155_AAA0);
        settle();

        // R12: reset in the middle of a frame
        word_in = 32'h0123_4560;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        word_in = '0;
        @(negedge clk);
        chk(dac_sync_n == 1'b1 && dac_sclk == 1'b1 && dac_din == 1'b0 && busy == 1'b0,
            "R12 mid-frame reset", {dac_sync_n, dac_sclk, dac_din, busy}, 32'hC);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        base = frame_cnt;
        repeat (200) @(negedge clk);
        chk(frame_cnt == base, "R12 no frame after reset", frame_cnt, base);

        chk(load_bad == 0, "R3 load line low", load_bad, 0);
        chk(busy_bad == 0, "R8 busy matches select", busy_bad, 0);
        chk(idle_bad == 0, "R6 idle levels", idle_bad, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule